// File: doc/BRIEF.md
# Double-Precision to 32-bit Integer Truncating Converter

This block takes one 64-bit IEEE-754 binary64 operand and returns the signed 32-bit integer closest to zero, that is, the truncated value. No rounding mode is consulted; the fraction is always discarded. Finite values beyond the 32-bit range, and both infinities, clamp to the nearest representable extreme. Every NaN produces the most-negative integer as a fixed marker.

Next to the integer, the block reports five status bits: invalid conversion, signalling NaN, inexact, invalid summary and exception summary. When the request carries the record flag, it also reports a 4-bit condition summary. The result sits in the low half of a 64-bit word whose upper half is zero. Operands enter through a valid/ready handshake. Each accepted operand yields one registered response a cycle later, and that response stays put until the consumer takes it.

Top module: `dbl_to_i32_trunc`

## Requirements
- R1: A finite operand whose truncated value lies in [-2147483648, 2147483647] gives that value, in two's complement, on out_result[31:0]. Because range is judged on the truncated value, -2147483648.7 gives 0x80000000 and is not invalid.
- R2: out_result[63:32] is always zero.
- R3: A positive operand whose truncated value exceeds 2147483647, including +infinity, gives 0x7FFFFFFF and sets the invalid-conversion flag.
- R4: A negative operand whose truncated value is below -2147483648, including -infinity, gives 0x80000000 and sets the invalid-conversion flag.
- R5: Any NaN (exponent all ones, fraction nonzero) gives 0x80000000 and sets invalid-conversion. When fraction bit 51 is clear (a signalling NaN), it also sets the signalling-NaN flag.
- R6: The inexact flag is set exactly when an in-range finite operand has a nonzero fractional part. It is never set together with invalid-conversion.
- R7: out_flags encodes bit 0 invalid-conversion, bit 1 signalling NaN, bit 2 inexact, bit 3 invalid summary, bit 4 exception summary. Bit 3 equals bit 0, and bit 4 equals bit 3 OR bit 2.
- R8: With the record bit set, out_cond is {exception summary, enabled-exception summary (always 0), invalid summary, overflow (always 0)}, most significant bit first. With the record bit clear, out_cond is 0000.
- R9: An operand accepted on a clock edge (in_valid and in_ready both high) appears with out_valid high after that edge. Once the response is consumed and no new operand is accepted, out_valid falls.
- R10: While out_valid is high and out_ready is low, in_ready is low, out_valid stays high, and out_result, out_flags and out_cond do not change. An operand offered during that time is not taken.
- R11: During reset, out_valid is 0 and in_ready is 1 even with out_ready low.
- R12: Zeros of either sign and subnormals give 0. A nonzero subnormal sets inexact, and a zero does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block can take an operand |
| in_operand | input | 64 | binary64 operand |
| in_record | input | 1 | Request the condition summary |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| out_result | output | 64 | Zero-extended 32-bit integer |
| out_flags | output | 5 | Status bits (see R7) |
| out_cond | output | 4 | Condition summary (see R8) |

## Verification
The bound checker watches, on every cycle, the properties that hold for any response. These are the zero upper half, the saturation values whenever invalid is raised, the marker value for signalling NaNs, the exclusion of inexact and invalid, the summary-bit relations, the constant-zero condition bits, the one-cycle latency and the holding of a stalled response. Only the bench's scenarios can show that each operand maps to the right integer and the right flags. The bench sweeps every exponent with both signs and several fraction patterns, then probes the exact range boundaries, subnormals, signed zeros, NaN kinds and a stalled consumer with a competing operand.

// File: rtl/f2i_pkg.sv
// Shared types for the binary64-to-int32 truncating converter.
// Assumes: the flag order below is the public encoding of out_flags.
package f2i_pkg;

    // Operand class decided from the exponent and fraction fields.
    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUBN,
        CLS_NORM,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } cls_t;

    // Status bits, MSB first: exception summary, invalid summary, inexact,
    // signalling NaN, invalid conversion.
    typedef struct packed {
        logic fx;
        logic vx;
        logic xx;
        logic snan;
        logic inv;
    } cvt_flags_t;

endpackage

// File: rtl/f2i_unpack.sv
// Splits a binary64 word into sign, class, unbiased exponent and significand.
// Assumes: IEEE-754 layout sign | exponent | fraction, the fraction MSB being
// the quiet bit for NaNs.
module f2i_unpack
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int DBL_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1,
    localparam int UNB_W = EXP_W + 2
) (
    input  logic                    [DBL_W-1:0] operand,
    output logic                                sign,
    output cls_t                                cls,
    output logic signed             [UNB_W-1:0] exp_unb,
    output logic                    [SIG_W-1:0] sig
);

    localparam int               BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] EXP_TOP = '1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac;

    // Field extraction and classification.
    always_comb begin
        sign    = operand[DBL_W-1];
        exp_f   = operand[DBL_W-2 -: EXP_W];
        frac    = operand[FRAC_W-1:0];
        exp_unb = $signed({2'b00, exp_f}) - $signed(UNB_W'(BIAS));
        sig     = {1'b1, frac};
        if (exp_f == '0) begin
            cls = (frac == '0) ? CLS_ZERO : CLS_SUBN;
        end else if (exp_f == EXP_TOP) begin
            if (frac == '0)             cls = CLS_INF;
            else if (frac[FRAC_W-1])    cls = CLS_QNAN;
            else                        cls = CLS_SNAN;
        end else begin
            cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/f2i_align.sv
// Right-shifts the significand of a normal operand to its integer magnitude
// and ORs the discarded bits into a sticky "lost" indication.
// Assumes: FRAC_W >= INT_W - 1, so every in-window shift is non-negative.
module f2i_align #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 32,
    localparam int SIG_W = FRAC_W + 1,
    localparam int UNB_W = EXP_W + 2,
    localparam int MAG_W = INT_W + 1,
    localparam int SH_W  = $clog2(SIG_W) + 1
) (
    input  logic        [SIG_W-1:0] sig,
    input  logic signed [UNB_W-1:0] exp_unb,
    output logic        [MAG_W-1:0] mag,
    output logic                    lost,
    output logic                    big
);

    logic [SH_W-1:0]  sh;
    logic [SIG_W-1:0] lost_mask;

    // Shift window: below 1.0 everything is lost, at 2^INT_W and up it is too big.
    always_comb begin
        mag       = '0;
        lost      = 1'b0;
        big       = 1'b0;
        sh        = '0;
        lost_mask = '0;
        if (exp_unb < 0) begin
            lost = |sig;
        end else if (exp_unb >= $signed(UNB_W'(INT_W))) begin
            big = 1'b1;
        end else begin
            sh        = SH_W'(FRAC_W) - SH_W'(exp_unb);
            mag       = MAG_W'(sig >> sh);
            lost_mask = (SIG_W'(1) << sh) - SIG_W'(1);
            lost      = |(sig & lost_mask);
        end
    end

endmodule

// File: rtl/f2i_pack.sv
// Applies sign, saturation and the NaN marker, and derives the status and
// condition bits.
// Assumes: mag and lost are meaningful only for CLS_NORM.
module f2i_pack
    import f2i_pkg::*;
#(
    parameter int INT_W  = 32,
    localparam int MAG_W = INT_W + 1
) (
    input  logic             sign,
    input  cls_t             cls,
    input  logic [MAG_W-1:0] mag,
    input  logic             lost,
    input  logic             big,
    input  logic             record,
    output logic [INT_W-1:0] res,
    output cvt_flags_t       flags,
    output logic [3:0]       cond
);

    localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [MAG_W-1:0] NEG_LIM = {2'b01, {(INT_W-1){1'b0}}};

    logic ovf;

    // Range test on the truncated magnitude: the negative side reaches one further.
    always_comb begin
        ovf = big | (sign ? (mag > NEG_LIM) : (mag >= NEG_LIM));
    end

    // Result selection and flag generation per operand class.
    always_comb begin
        res   = '0;
        flags = '0;
        unique case (cls)
            CLS_ZERO: res = '0;
            CLS_SUBN: flags.xx = 1'b1;
            CLS_INF: begin
                flags.inv = 1'b1;
                res       = sign ? NEG_MIN : POS_MAX;
            end
            CLS_QNAN: begin
                flags.inv = 1'b1;
                res       = NEG_MIN;
            end
            CLS_SNAN: begin
                flags.inv  = 1'b1;
                flags.snan = 1'b1;
                res        = NEG_MIN;
            end
            default: begin
                if (ovf) begin
                    flags.inv = 1'b1;
                    res       = sign ? NEG_MIN : POS_MAX;
                end else begin
                    res      = sign ? (INT_W'(0) - mag[INT_W-1:0]) : mag[INT_W-1:0];
                    flags.xx = lost;
                end
            end
        endcase
        flags.vx = flags.inv;
        flags.fx = flags.inv | flags.xx;
        cond     = record ? {flags.fx, 1'b0, flags.vx, 1'b0} : 4'b0000;
    end

endmodule

// File: rtl/dbl_to_i32_trunc.sv
// Top: truncating binary64 -> int32 converter with one register stage and a
// valid/ready handshake on both sides.
// Assumes: a response is held until out_ready; a new operand is taken only
// when the output slot is empty or being drained in the same cycle.
module dbl_to_i32_trunc
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 32,
    localparam int DBL_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1,
    localparam int UNB_W = EXP_W + 2,
    localparam int MAG_W = INT_W + 1,
    localparam int FLG_W = $bits(cvt_flags_t),
    localparam int PAD_W = DBL_W - INT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DBL_W-1:0] in_operand,
    input  logic             in_record,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DBL_W-1:0] out_result,
    output logic [FLG_W-1:0] out_flags,
    output logic [3:0]       out_cond
);

    logic                    sign;
    cls_t                    cls;
    logic signed [UNB_W-1:0] exp_unb;
    logic [SIG_W-1:0]        sig;
    logic [MAG_W-1:0]        mag;
    logic                    lost;
    logic                    big;
    logic [INT_W-1:0]        nxt_res;
    cvt_flags_t              nxt_flags;
    logic [3:0]              nxt_cond;

    f2i_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
        .operand (in_operand),
        .sign    (sign),
        .cls     (cls),
        .exp_unb (exp_unb),
        .sig     (sig)
    );

    f2i_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
        .sig     (sig),
        .exp_unb (exp_unb),
        .mag     (mag),
        .lost    (lost),
        .big     (big)
    );

    f2i_pack #(.INT_W(INT_W)) u_pack (
        .sign    (sign),
        .cls     (cls),
        .mag     (mag),
        .lost    (lost),
        .big     (big),
        .record  (in_record),
        .res     (nxt_res),
        .flags   (nxt_flags),
        .cond    (nxt_cond)
    );

    // Slot is free when empty or when its content leaves this cycle.
    assign in_ready = !out_valid || out_ready;

    // Output register: load on accept, clear valid on drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_flags  <= '0;
            out_cond   <= '0;
        end else if (in_valid && in_ready) begin
            out_valid  <= 1'b1;
            out_result <= {{PAD_W{1'b0}}, nxt_res};
            out_flags  <= nxt_flags;
            out_cond   <= nxt_cond;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
        end
    end

endmodule

// File: rtl/dbl_to_i32_trunc_checker.sv
// Cycle-by-cycle properties of the converter's ports, bound to the top.
module dbl_to_i32_trunc_checker #(
    parameter int DBL_W = 64,
    parameter int INT_W = 32,
    parameter int FLG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [DBL_W-1:0] out_result,
    input logic [FLG_W-1:0] out_flags,
    input logic [3:0]       out_cond
);

    localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_result[DBL_W-1:INT_W] == '0);

    p_sat_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[0]) |->
            (out_result[INT_W-1:0] == POS_MAX || out_result[INT_W-1:0] == NEG_MIN));

    p_snan_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[1]) |-> (out_flags[0] && out_result[INT_W-1:0] == NEG_MIN));

    p_inv_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_flags[0] && out_flags[2]));

    p_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_flags[3] == out_flags[0] && out_flags[4] == (out_flags[3] | out_flags[2])));

    p_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cond[2] == 1'b0 && out_cond[0] == 1'b0 &&
            (out_cond == 4'b0000 || (out_cond[3] == out_flags[4] && out_cond[1] == out_flags[3]))));

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_cond)));

    p_stall_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

bind dbl_to_i32_trunc dbl_to_i32_trunc_checker #(
    .DBL_W (DBL_W),
    .INT_W (INT_W),
    .FLG_W (FLG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result),
    .out_flags  (out_flags),
    .out_cond   (out_cond)
);

// File: tb/dbl_to_i32_trunc_test.sv
// Sweeps every exponent with both signs and several fractions, then probes
// boundaries and backpressure; expected values come from real arithmetic.
module dbl_to_i32_trunc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_operand = '0;
    logic        in_record = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_result;
    logic [4:0]  out_flags;
    logic [3:0]  out_cond;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    always #2 clk = ~clk;

    dbl_to_i32_trunc uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_operand (in_operand),
        .in_record  (in_record),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_result (out_result),
        .out_flags  (out_flags),
        .out_cond   (out_cond)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h (operand %h)", tag, act, exp, in_operand);
        end
    endtask

    function automatic logic [63:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    // Reference: expected integer, flags {fx,vx,xx,snan,inv}, and requirement tag.
    task automatic model(input logic [63:0] b, output logic [31:0] r,
                         output logic [4:0] f, output string tag);
        logic inv, snan, xx;
        real  x;
        int   t;
        inv = 0; snan = 0; xx = 0;
        if (b[62:52] == 11'h7FF) begin
            if (b[51:0] != 0) begin
                r = 32'h8000_0000; inv = 1; snan = !b[51]; tag = "R5";
            end else begin
                r = b[63] ? 32'h8000_0000 : 32'h7FFF_FFFF; inv = 1;
                tag = b[63] ? "R4" : "R3";
            end
        end else begin
            x = $bitstoreal(b);
            if (x >= 2147483648.0) begin
                r = 32'h7FFF_FFFF; inv = 1; tag = "R3";
            end else if (x <= -2147483649.0) begin
                r = 32'h8000_0000; inv = 1; tag = "R4";
            end else begin
                t  = $rtoi(x);
                r  = t;
                xx = ($itor(t) != x);
                tag = (b[62:52] == 0) ? "R12" : "R1";
            end
        end
        f = {inv | xx, inv, xx, snan, inv};
    endtask

    // Offer one operand at a falling edge and check the response one edge later.
    task automatic run_op(input logic [63:0] b, input bit rec);
        logic [31:0] er;
        logic [4:0]  ef;
        string       tag;
        model(b, er, ef, tag);
        in_operand = b;
        in_record  = rec;
        in_valid   = 1'b1;
        @(negedge clk);
        check("R9 valid", {63'd0, out_valid}, 64'd1);
        check(tag, {32'd0, out_result[31:0]}, {32'd0, er});
        check("R2 upper", {32'd0, out_result[63:32]}, 64'd0);
        check("R6 R7 flags", {59'd0, out_flags}, {59'd0, ef});
        check("R8 cond", {60'd0, out_cond}, rec ? {60'd0, ef[4], 1'b0, ef[3], 1'b0} : 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] x_op, y_op, b;
        logic [51:0] fr;
        // R11: reset state with a stalled consumer.
        repeat (3) @(negedge clk);
        check("R11 valid", {63'd0, out_valid}, 64'd0);
        check("R11 ready", {63'd0, in_ready}, 64'd1);
        rst_n = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);

        // Exhaustive exponent sweep, both signs, four fraction patterns.
        for (int e = 0; e < 2048; e++) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 4; k++) begin
                    case (k)
                        0:       fr = '0;
                        1:       fr = '1;
                        2:       fr = 52'h8_0000_0000_0000;
                        default: fr = next_rand()[51:0];
                    endcase
                    b = {s[0], e[10:0], fr};
                    run_op(b, e[0] ^ k[0]);
                end
            end
        end

        // Boundary probes (R1, R3, R4, R5, R6, R12).
        run_op($realtobits(2147483647.9), 1'b1);
        run_op($realtobits(2147483648.0), 1'b1);
        run_op($realtobits(-2147483648.7), 1'b1);
        run_op($realtobits(-2147483648.0), 1'b0);
        run_op($realtobits(-2147483649.0), 1'b1);
        run_op($realtobits(0.5), 1'b1);
        run_op($realtobits(-0.5), 1'b0);
        run_op($realtobits(-1.5), 1'b1);
        run_op($realtobits(123456.0), 1'b1);
        run_op($realtobits(-7.25), 1'b1);
        run_op(64'h8000_0000_0000_0000, 1'b1);
        run_op(64'h0000_0000_0000_0001, 1'b1);
        run_op(64'h7FF0_0000_0000_0001, 1'b1);
        run_op(64'hFFF0_0000_0000_0001, 1'b0);
        run_op(64'hFFF8_0000_0000_0000, 1'b1);
        run_op(64'hFFF0_0000_0000_0000, 1'b1);

        // R10: stalled response holds and refuses a competing operand.
        in_valid = 1'b0;
        @(negedge clk);
        x_op = $realtobits(-42.75);
        y_op = $realtobits(99.0);
        out_ready = 1'b0;
        in_operand = x_op; in_record = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R9 stall load", {63'd0, out_valid}, 64'd1);
        check("R1 stall value", out_result, 64'h0000_0000_FFFF_FFD6);
        in_operand = y_op; in_record = 1'b0;
        check("R10 ready low", {63'd0, in_ready}, 64'd0);
        repeat (3) @(negedge clk);
        check("R10 held valid", {63'd0, out_valid}, 64'd1);
        check("R10 held value", out_result, 64'h0000_0000_FFFF_FFD6);
        check("R10 held flags", {59'd0, out_flags}, 64'h14);
        check("R10 held cond", {60'd0, out_cond}, 64'h8);
        out_ready = 1'b1;
        @(negedge clk);
        check("R9 second", out_result, 64'd99);
        check("R8 no record", {60'd0, out_cond}, 64'd0);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 drained", {63'd0, out_valid}, 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule